// File: doc/BRIEF.md
# Interrupt Source Event Router

The router keeps a table of interrupt sources. Every source carries a two-bit pending/queued state, a mask bit, a message/level type flag and a route: a 31-bit event word, a target CPU and a priority. A trigger on a source first moves its state. When the state machine decides that the event goes out, and the source is not masked, the router writes one 32-bit entry into the circular event queue chosen by the CPU and priority. That queue's write index then advances by one, wraps at the queue's size, and flips a generation bit on every wrap.

Software uses one write-only register port. Through it, software fills in source routes, forces a source's state, sets each queue's size and base address, and issues end-of-interrupt. An end-of-interrupt can release an event that was held back, so it may also cause a queue write. Each accepted cycle causes at most one queue write. A register write wins over a trigger that arrives in the same cycle, and that trigger is lost. Every queue write shows up on registered outputs one clock after the edge that accepted the operation.

Top module: `ir_event_router`

## Requirements
- R1: After reset every source is off (state 01) and masked, every queue has index 0 and generation bit 1, and qw_valid is low. A trigger on a source that has never been configured produces no write.
- R2: A trigger on a source in state 00 (ready) moves it to 10 (pending). If the source is unmasked, qw_valid goes high on the edge after the trigger, for exactly one cycle.
- R3: For a message source, a trigger in state 10 or 11 leaves the source in 11 (queued) and writes nothing.
- R4: A source in state 01 (off) ignores both triggers and end-of-interrupt. It stays off and writes nothing.
- R5: End-of-interrupt in state 10 returns the source to 00 and writes nothing. End-of-interrupt in state 11 moves it to 10 and writes one entry.
- R6: A masked source writes nothing, but its state still advances. After unmasking, an end-of-interrupt on its queued state writes one entry.
- R7: For a level source, a trigger while pending leaves it in 10. The following end-of-interrupt therefore writes nothing.
- R8: The target queue number is cpu*NUM_PRIO + prio. qw_addr is the queue base plus the current index, counted in entries. qw_data is {generation bit, event word[30:0]}.
- R9: Each write advances the queue index by one. A write at index 2^size-1 wraps the index to 0 and inverts the generation bit. Size values above 14 are clamped to 14, giving 16384 entries.
- R10: When cfg_we is high in the same cycle as trig_valid, the trigger is dropped. The source state does not change and nothing is written.
- R11: Triggers and register writes that name a source at or above SRC_DEPTH are ignored. They do not alias onto lower entries.
- R12: cfg_op codes: 0 writes the event word (cfg_wdata[30:0]); 1 writes control ([0] mask, [1] level, [3:2] cpu, [6:4] priority); 2 writes state ([1:0]); 3 writes queue size ([4:0], log2); 4 writes queue base; 5 is end-of-interrupt. For codes 3 and 4, cfg_idx selects the queue. Code 3 also resets that queue to index 0 with generation bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_src | input | 13 | Source number of the trigger |
| cfg_we | input | 1 | Register write / end-of-interrupt strobe |
| cfg_op | input | 3 | Operation code |
| cfg_idx | input | 13 | Source number or queue number |
| cfg_wdata | input | 32 | Write data |
| qw_valid | output | 1 | Queue entry write strobe |
| qw_queue | output | 5 | Queue number written |
| qw_addr | output | 32 | Entry address (base + index) |
| qw_data | output | 32 | Entry: generation bit over event word |

## Verification
A corrupted pending/queued state shows up only at a later event. The symptom is an extra or missing write on the next trigger or end-of-interrupt for that source, so the bench follows each source through full trigger/EOI sequences instead of single operations. A wrong queue index or generation bit shows on qw_addr or qw_data in the cycle right after the next write to that queue. A wrap error shows at the 2^size-th write, which is why the bench runs one queue through a full 16384-entry cycle. Aliasing of out-of-range sources is caught with a following end-of-interrupt that would otherwise release a write.

// File: rtl/ir_route_pkg.sv
package ir_route_pkg;

  localparam logic [1:0] PQ_READY  = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  typedef enum logic [2:0] {
    OP_SRC_DATA = 3'd0,
    OP_SRC_CTRL = 3'd1,
    OP_SRC_PQ   = 3'd2,
    OP_Q_SIZE   = 3'd3,
    OP_Q_BASE   = 3'd4,
    OP_EOI      = 3'd5
  } cfg_op_e;

  typedef struct packed {
    logic [1:0] pq;
    logic       fwd;
  } pq_step_t;

  // Trigger arrival: ready forwards, pending/queued merge, off drops.
  function automatic pq_step_t pq_on_trigger(input logic [1:0] pq, input logic level);
    pq_step_t s;
    s.pq  = pq;
    s.fwd = 1'b0;
    case (pq)
      PQ_READY:  begin s.pq = PQ_PEND; s.fwd = 1'b1; end
      PQ_PEND:   s.pq = level ? PQ_PEND : PQ_QUEUED;
      PQ_QUEUED: s.pq = PQ_QUEUED;
      default:   s.pq = PQ_OFF;
    endcase
    return s;
  endfunction

  // End-of-interrupt: pending clears, queued replays one event.
  function automatic pq_step_t pq_on_eoi(input logic [1:0] pq);
    pq_step_t s;
    s.pq  = pq;
    s.fwd = 1'b0;
    case (pq)
      PQ_PEND:   s.pq = PQ_READY;
      PQ_QUEUED: begin s.pq = PQ_PEND; s.fwd = 1'b1; end
      default:   s.pq = pq;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ir_src_table.sv
module ir_src_table
  import ir_route_pkg::*;
#(
  parameter int SRC_ID_W  = 13,
  parameter int SRC_DEPTH = 64,
  parameter int CPU_W     = 2,
  parameter int PRIO_W    = 3,
  parameter int DATA_W    = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_go,
  input  logic [SRC_ID_W-1:0] trig_id,
  input  logic                cfg_we,
  input  cfg_op_e             cfg_op,
  input  logic [SRC_ID_W-1:0] cfg_id,
  input  logic [31:0]         cfg_wdata,
  output logic                fwd,
  output logic [DATA_W-1:0]   fwd_data,
  output logic [CPU_W-1:0]    fwd_cpu,
  output logic [PRIO_W-1:0]   fwd_prio
);

  localparam int AW = (SRC_DEPTH > 1) ? $clog2(SRC_DEPTH) : 1;
  localparam logic [SRC_ID_W:0] DEPTH_L = (SRC_ID_W+1)'(SRC_DEPTH);
  localparam int CPU_LSB  = 2;
  localparam int PRIO_LSB = 2 + CPU_W;

  // State and mask need a reset value; route fields live in RAM-style arrays.
  logic [1:0]        pq_q    [SRC_DEPTH];
  logic              mask_q  [SRC_DEPTH];
  logic              level_q [SRC_DEPTH];
  logic [CPU_W-1:0]  cpu_q   [SRC_DEPTH];
  logic [PRIO_W-1:0] prio_q  [SRC_DEPTH];
  logic [DATA_W-1:0] data_q  [SRC_DEPTH];

  logic          cfg_hit, trig_hit, eoi_hit, pq_we;
  logic [AW-1:0] act_idx;
  logic [1:0]    cur_pq, nxt_pq;
  logic          fwd_raw;
  pq_step_t      step;

  assign cfg_hit  = cfg_we  && ({1'b0, cfg_id}  < DEPTH_L);
  assign trig_hit = trig_go && ({1'b0, trig_id} < DEPTH_L);
  assign eoi_hit  = cfg_hit && (cfg_op == OP_EOI);
  assign act_idx  = cfg_we ? cfg_id[AW-1:0] : trig_id[AW-1:0];
  assign cur_pq   = pq_q[act_idx];

  always_comb begin
    nxt_pq  = cur_pq;
    fwd_raw = 1'b0;
    pq_we   = 1'b0;
    step    = '0;
    if (eoi_hit) begin
      step    = pq_on_eoi(cur_pq);
      nxt_pq  = step.pq;
      fwd_raw = step.fwd;
      pq_we   = 1'b1;
    end else if (trig_hit) begin
      step    = pq_on_trigger(cur_pq, level_q[act_idx]);
      nxt_pq  = step.pq;
      fwd_raw = step.fwd;
      pq_we   = 1'b1;
    end else if (cfg_hit && cfg_op == OP_SRC_PQ) begin
      nxt_pq = cfg_wdata[1:0];
      pq_we  = 1'b1;
    end
  end

  assign fwd      = fwd_raw && !mask_q[act_idx];
  assign fwd_data = data_q[act_idx];
  assign fwd_cpu  = cpu_q[act_idx];
  assign fwd_prio = prio_q[act_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SRC_DEPTH; i++) begin
        pq_q[i]   <= PQ_OFF;
        mask_q[i] <= 1'b1;
      end
    end else begin
      if (pq_we) pq_q[act_idx] <= nxt_pq;
      if (cfg_hit && cfg_op == OP_SRC_CTRL) mask_q[act_idx] <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_hit && cfg_op == OP_SRC_CTRL) begin
      level_q[act_idx] <= cfg_wdata[1];
      cpu_q[act_idx]   <= cfg_wdata[CPU_LSB +: CPU_W];
      prio_q[act_idx]  <= cfg_wdata[PRIO_LSB +: PRIO_W];
    end
    if (cfg_hit && cfg_op == OP_SRC_DATA) data_q[act_idx] <= cfg_wdata[DATA_W-1:0];
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, cfg_wdata};

  a_r2_ready_forwards: assert property (@(posedge clk) disable iff (rst)
    (trig_hit && !cfg_we && cur_pq == PQ_READY && !mask_q[act_idx]) |-> fwd);

  a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
    ((trig_hit || eoi_hit) && cur_pq == PQ_OFF) |-> (!fwd && nxt_pq == PQ_OFF));

  a_r5_queued_replays: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit && cur_pq == PQ_QUEUED && !mask_q[act_idx]) |-> fwd);

  a_r7_level_no_merge: assert property (@(posedge clk) disable iff (rst)
    (trig_hit && !cfg_we && level_q[act_idx] && cur_pq == PQ_PEND) |-> (nxt_pq == PQ_PEND && !fwd));

endmodule

// File: rtl/ir_queue_ctl.sv
module ir_queue_ctl #(
  parameter int NUM_Q    = 32,
  parameter int QID_W    = 5,
  parameter int LOG2_MAX = 14,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [QID_W-1:0]  push_q,
  input  logic              size_we,
  input  logic              base_we,
  input  logic [QID_W-1:0]  cfg_q,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_tog
);

  localparam int LG_W = $clog2(LOG2_MAX + 1);

  logic [LOG2_MAX-1:0] idx_q  [NUM_Q];
  logic                tog_q  [NUM_Q];
  logic [LG_W-1:0]     lg_q   [NUM_Q];
  logic [ADDR_W-1:0]   base_q [NUM_Q];
  logic [LOG2_MAX-1:0] lim    [NUM_Q];
  logic [LG_W-1:0]     lg_in;

  assign lg_in = (cfg_wdata[4:0] > 5'(LOG2_MAX)) ? LG_W'(LOG2_MAX) : LG_W'(cfg_wdata[4:0]);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_lim
    assign lim[g] = LOG2_MAX'(((LOG2_MAX+1)'(1) << lg_q[g]) - (LOG2_MAX+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_Q; i++) begin
        idx_q[i]  <= '0;
        tog_q[i]  <= 1'b1;
        lg_q[i]   <= '0;
        base_q[i] <= '0;
      end
    end else begin
      if (size_we) begin
        lg_q[cfg_q]  <= lg_in;
        idx_q[cfg_q] <= '0;
        tog_q[cfg_q] <= 1'b1;
      end
      if (base_we) base_q[cfg_q] <= cfg_wdata[ADDR_W-1:0];
      if (push) begin
        if (idx_q[push_q] == lim[push_q]) begin
          idx_q[push_q] <= '0;
          tog_q[push_q] <= ~tog_q[push_q];
        end else begin
          idx_q[push_q] <= idx_q[push_q] + 1'b1;
        end
      end
    end
  end

  assign slot_addr = base_q[push_q] + ADDR_W'(idx_q[push_q]);
  assign slot_tog  = tog_q[push_q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    a_r9_index_in_range: assert property (@(posedge clk) disable iff (rst)
      idx_q[g] <= lim[g]);

    a_r9_wrap_flips: assert property (@(posedge clk) disable iff (rst)
      (push && !size_we && push_q == QID_W'(g) && idx_q[g] == lim[g])
        |=> (idx_q[g] == '0 && tog_q[g] != $past(tog_q[g])));

    a_r9_step_one: assert property (@(posedge clk) disable iff (rst)
      (push && !size_we && push_q == QID_W'(g) && idx_q[g] != lim[g])
        |=> (idx_q[g] == $past(idx_q[g]) + 1'b1 && $stable(tog_q[g])));

    a_r12_size_resets: assert property (@(posedge clk) disable iff (rst)
      (size_we && cfg_q == QID_W'(g)) |=> (idx_q[g] == '0 && tog_q[g]));
  end

endmodule

// File: rtl/ir_event_router.sv
module ir_event_router
  import ir_route_pkg::*;
#(
  parameter int SRC_ID_W  = 13,
  parameter int SRC_DEPTH = 64,
  parameter int NUM_CPU   = 4,
  parameter int NUM_PRIO  = 8,
  parameter int LOG2_MAX  = 14,
  parameter int ADDR_W    = 32
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           trig_valid,
  input  logic [SRC_ID_W-1:0]                            trig_src,
  input  logic                                           cfg_we,
  input  logic [2:0]                                     cfg_op,
  input  logic [SRC_ID_W-1:0]                            cfg_idx,
  input  logic [31:0]                                    cfg_wdata,
  output logic                                           qw_valid,
  output logic [$clog2(NUM_CPU)+$clog2(NUM_PRIO)-1:0]    qw_queue,
  output logic [ADDR_W-1:0]                              qw_addr,
  output logic [31:0]                                    qw_data
);

  localparam int CPU_W  = $clog2(NUM_CPU);
  localparam int PRIO_W = $clog2(NUM_PRIO);
  localparam int QID_W  = CPU_W + PRIO_W;
  localparam int NUM_Q  = NUM_CPU * NUM_PRIO;
  localparam int DATA_W = 31;

  cfg_op_e           op;
  logic              trig_go;
  logic              fwd;
  logic [DATA_W-1:0] fwd_data;
  logic [CPU_W-1:0]  fwd_cpu;
  logic [PRIO_W-1:0] fwd_prio;
  logic [QID_W-1:0]  qsel;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_tog;

  assign op      = cfg_op_e'(cfg_op);
  assign trig_go = trig_valid && !cfg_we;

  ir_src_table #(
    .SRC_ID_W (SRC_ID_W),
    .SRC_DEPTH(SRC_DEPTH),
    .CPU_W    (CPU_W),
    .PRIO_W   (PRIO_W),
    .DATA_W   (DATA_W)
  ) u_src (
    .clk      (clk),
    .rst      (rst),
    .trig_go  (trig_go),
    .trig_id  (trig_src),
    .cfg_we   (cfg_we),
    .cfg_op   (op),
    .cfg_id   (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .fwd      (fwd),
    .fwd_data (fwd_data),
    .fwd_cpu  (fwd_cpu),
    .fwd_prio (fwd_prio)
  );

  assign qsel = {fwd_cpu, fwd_prio};

  ir_queue_ctl #(
    .NUM_Q   (NUM_Q),
    .QID_W   (QID_W),
    .LOG2_MAX(LOG2_MAX),
    .ADDR_W  (ADDR_W)
  ) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (fwd),
    .push_q   (qsel),
    .size_we  (cfg_we && op == OP_Q_SIZE),
    .base_we  (cfg_we && op == OP_Q_BASE),
    .cfg_q    (cfg_idx[QID_W-1:0]),
    .cfg_wdata(cfg_wdata),
    .slot_addr(slot_addr),
    .slot_tog (slot_tog)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qw_valid <= 1'b0;
      qw_queue <= '0;
      qw_addr  <= '0;
      qw_data  <= '0;
    end else begin
      qw_valid <= fwd;
      qw_queue <= qsel;
      qw_addr  <= slot_addr;
      qw_data  <= {slot_tog, fwd_data};
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !qw_valid);

  a_r10_cfg_beats_trigger: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_op != 3'd5) |=> !qw_valid);

  a_r2_single_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    (!trig_valid && !cfg_we) |=> !qw_valid);

endmodule

// File: tb/ir_event_router_test.sv
module ir_event_router_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_valid = 1'b0;
  logic [12:0] trig_src = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_op = '0;
  logic [12:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        qw_valid;
  logic [4:0]  qw_queue;
  logic [31:0] qw_addr;
  logic [31:0] qw_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_event_router uut (
    .clk(clk), .rst(rst),
    .trig_valid(trig_valid), .trig_src(trig_src),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .qw_valid(qw_valid), .qw_queue(qw_queue), .qw_addr(qw_addr), .qw_data(qw_data)
  );

  // {eoi, src, expect write, queue, addr, data}
  localparam logic [83:0] VEC [NVEC] = '{
    {1'b0, 13'd1,     1'b1, 5'd10, 32'h1000, 32'h8000_0010}, // R2
    {1'b0, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0},         // R3
    {1'b0, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0},         // R3
    {1'b1, 13'd1,     1'b1, 5'd10, 32'h1001, 32'h8000_0010}, // R5 queued replay
    {1'b1, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0},         // R5 pending clears
    {1'b0, 13'd1,     1'b1, 5'd10, 32'h1002, 32'h8000_0010}, // R8
    {1'b1, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0},
    {1'b0, 13'd1,     1'b1, 5'd10, 32'h1003, 32'h8000_0010}, // R9 last slot
    {1'b1, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0},
    {1'b0, 13'd1,     1'b1, 5'd10, 32'h1000, 32'h0000_0010}, // R9 wrapped
    {1'b0, 13'd0,     1'b0, 5'd0,  32'h0,    32'h0},         // R4
    {1'b1, 13'd0,     1'b0, 5'd0,  32'h0,    32'h0},         // R4
    {1'b0, 13'd2,     1'b1, 5'd3,  32'h2000, 32'h8000_0022}, // R7 / R9 size 1
    {1'b0, 13'd2,     1'b0, 5'd0,  32'h0,    32'h0},         // R7
    {1'b1, 13'd2,     1'b0, 5'd0,  32'h0,    32'h0},         // R7
    {1'b0, 13'd2,     1'b1, 5'd3,  32'h2000, 32'h0000_0022}, // R9
    {1'b0, 13'd3,     1'b0, 5'd0,  32'h0,    32'h0},         // R6
    {1'b0, 13'd3,     1'b0, 5'd0,  32'h0,    32'h0},         // R6
    {1'b0, 13'h1001,  1'b0, 5'd0,  32'h0,    32'h0},         // R11
    {1'b1, 13'd1,     1'b0, 5'd0,  32'h0,    32'h0}          // R11 no alias
  };

  task automatic cycle(input logic we, input logic [2:0] op, input logic [12:0] id,
                       input logic [31:0] wd, input logic tv, input logic [12:0] ts);
    @(negedge clk);
    cfg_we = we; cfg_op = op; cfg_idx = id; cfg_wdata = wd;
    trig_valid = tv; trig_src = ts;
    @(posedge clk);
    #1;
    cfg_we = 1'b0; trig_valid = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] op, input logic [12:0] id, input logic [31:0] wd);
    cycle(1'b1, op, id, wd, 1'b0, '0);
  endtask

  task automatic trig(input logic [12:0] s);
    cycle(1'b0, 3'd0, '0, '0, 1'b1, s);
  endtask

  task automatic eoi(input logic [12:0] s);
    cfg(3'd5, s, '0);
  endtask

  task automatic chk(input string req, input logic ev, input logic [4:0] eq,
                     input logic [31:0] ea, input logic [31:0] ed);
    n_chk++;
    if (qw_valid !== ev || (ev && (qw_queue !== eq || qw_addr !== ea || qw_data !== ed))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b q=%0d a=%h d=%h, expected v=%0b q=%0d a=%h d=%h",
               req, qw_valid, qw_queue, qw_addr, qw_data, ev, eq, ea, ed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset output", 1'b0, '0, '0, '0);
    trig(13'd1);
    chk("R1 unconfigured source off", 1'b0, '0, '0, '0);
    cfg(3'd0, 13'd5, 32'h55);
    cfg(3'd2, 13'd5, 32'h0);
    trig(13'd5);
    chk("R1 reset mask", 1'b0, '0, '0, '0);

    // R12 configuration
    cfg(3'd0, 13'd1, 32'h10);   cfg(3'd1, 13'd1, 32'h24);  cfg(3'd2, 13'd1, 32'h0);
    cfg(3'd0, 13'd2, 32'h22);   cfg(3'd1, 13'd2, 32'h32);  cfg(3'd2, 13'd2, 32'h0);
    cfg(3'd0, 13'd3, 32'h33);   cfg(3'd1, 13'd3, 32'h25);  cfg(3'd2, 13'd3, 32'h0);
    cfg(3'd0, 13'd0, 32'h44);   cfg(3'd1, 13'd0, 32'h0);
    cfg(3'd4, 13'd10, 32'h1000); cfg(3'd3, 13'd10, 32'd2);
    cfg(3'd4, 13'd3, 32'h2000);  cfg(3'd3, 13'd3, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][83]) eoi(VEC[i][82:70]);
      else            trig(VEC[i][82:70]);
      chk($sformatf("R2 R3 R5 R7 R8 R11 vector %0d", i),
          VEC[i][69], VEC[i][68:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R6: unmask the queued source, EOI releases one entry
    cfg(3'd1, 13'd3, 32'h24);
    eoi(13'd3);
    chk("R6 unmasked replay", 1'b1, 5'd10, 32'h1001, 32'h0000_0033);

    // R10: simultaneous register write drops the trigger
    cycle(1'b1, 3'd0, 13'd6, 32'h66, 1'b1, 13'd1);
    chk("R10 trigger dropped", 1'b0, '0, '0, '0);
    trig(13'd1);
    chk("R10 state untouched", 1'b1, 5'd10, 32'h1002, 32'h0000_0010);

    // R12: size write resets index and generation
    cfg(3'd3, 13'd10, 32'd2);
    eoi(13'd1);
    trig(13'd1);
    chk("R12 queue reset", 1'b1, 5'd10, 32'h1000, 32'h8000_0010);

    // R9: clamp to 16384 entries and wrap
    cfg(3'd3, 13'd10, 32'd31);
    for (int i = 0; i < 16384; i++) begin
      eoi(13'd1);
      trig(13'd1);
      if (i == 16383) chk("R9 last of 16384", 1'b1, 5'd10, 32'h4FFF, 32'h8000_0010);
    end
    eoi(13'd1);
    trig(13'd1);
    chk("R9 wrap after 16384", 1'b1, 5'd10, 32'h1000, 32'h0000_0010);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule